// File: doc/BRIEF.md
# Flow-Through Burst SRAM

This block is a clocked static memory of 32-bit words. Its address and control inputs are registered, but the read data path has no register. The word addressed on a rising edge therefore drives the output in the cycle that follows that edge, with no extra pipeline stage. A write is decided late: the byte lanes to write are sampled at the closing edge of the access cycle. They are held for one cycle in a write register and then committed to the array. A read of that word in the next cycle is served by merging the held bytes over the array word.

A single loaded address produces a group of four beats. A two-bit beat counter steps once per cycle while the hold input is low. It can walk the low two address bits in linear order (start plus beat, modulo 4) or in interleaved order (start XOR beat). The upper address bits never change during a group. Two load strobes start accesses: a processor strobe, which is qualified by the main enable, and a controller strobe. Three enables decide whether a load selects or deselects the device. A sleep input freezes all access, and a separate output enable only gates the output drivers. The bidirectional data bus appears as separate input and output buses plus a drive-enable.

Top module: `fl_burst_sram`

## Requirements
- R1: After synchronous reset, the device is deselected and `dout_oe` is low until a selecting load.
- R2: A load with `en_main`, `sel_a` and `sel_b` all high captures `addr`. In the cycle right after that edge, `dout_oe` is high (with `oe` high) and `dout` holds the word at the loaded address.
- R3: With `lin_order` high at load, beat k (0 to 3) addresses low bits (start + k) mod 4. The counter steps once per edge while `adv_hold` is low, wraps from the fourth beat back to the first, and leaves the upper address bits unchanged.
- R4: With `lin_order` low at load, beat k addresses low bits start XOR k.
- R5: While `adv_hold` is high, with no load, the beat does not change and the same word repeats on the next cycle.
- R6: `wr_all` high writes all four byte lanes of the current word with `din`, whatever `wr_bytes_en` and `wr_lane` are.
- R7: With `wr_all` low and `wr_bytes_en` high, only the lanes whose `wr_lane[i]` bit is set are written (lane i is data bits 8i+7 down to 8i). With `wr_bytes_en` low, `wr_lane` writes nothing.
- R8: A read of a word in the cycle right after a write to it returns the newly written bytes merged with its unchanged bytes.
- R9: `cpu_ld` is ignored while `en_main` is low: the running burst continues as if no strobe had been given.
- R10: A `ctl_ld` with any of the three enables low deselects the device, as does a `cpu_ld` with `en_main` high and `sel_a` or `sel_b` low. In either case `dout_oe` is low from the next cycle.
- R11: `oe` gates `dout_oe` combinationally in the same cycle and has no effect on the address, burst or array state.
- R12: While `sleep` is high, `dout_oe` is low, and loads, beat steps and new writes taken at that edge have no effect. Array contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address captured by a load |
| cpu_ld | input | 1 | Processor load strobe, needs `en_main` |
| ctl_ld | input | 1 | Controller load strobe |
| adv_hold | input | 1 | High holds the beat, low steps it |
| lin_order | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| en_main | input | 1 | Main enable, active high |
| sel_a | input | 1 | Second enable, active high |
| sel_b | input | 1 | Third enable, active high |
| wr_all | input | 1 | Write all four lanes |
| wr_bytes_en | input | 1 | Enables the per-lane selects |
| wr_lane | input | 4 | Per-lane write selects |
| din | input | 32 | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down, blocks every access |
| dout | output | 32 | Flow-through read data |
| dout_oe | output | 1 | Drive-enable for the data bus |

## Verification
The properties take for granted that the load strobes and enables are stable binary values at each edge, and that `sleep` and `rst` are never X after time zero. The burst-step and hold properties apply only to edges with no load strobe at all, so they assume that a strobe, even an ignored one, may change the beat. The stimulus changes every input only on the falling edge and sets all controls to known idle values before each cycle. The one ignored processor strobe it issues is checked through the data it observes, not by the step property.

// File: rtl/fl_sram_pkg.sv
package fl_sram_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [1:0]        beat_t;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;

    typedef struct packed {
        logic       vld;
        lane_mask_t be;
        word_t      data;
    } wr_req_t;

    // low address bits of a given beat inside a four-word group
    function automatic beat_t burst_low(input beat_t start, input beat_t k, input order_e ord);
        beat_t r;
        if (ord == ORD_LINEAR) r = start + k;
        else                   r = start ^ k;
        return r;
    endfunction

    // lanes selected by the write controls of one cycle
    function automatic lane_mask_t lane_pick(input logic all_lanes, input logic bytes_en,
                                             input lane_mask_t sel);
        lane_mask_t m;
        if (all_lanes)     m = '1;
        else if (bytes_en) m = sel;
        else               m = '0;
        return m;
    endfunction

endpackage

// File: rtl/fl_burst_seq.sv
module fl_burst_seq
    import fl_sram_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_ld,
    input  logic              ctl_ld,
    input  logic              adv_hold,
    input  logic              lin_order,
    input  logic              en_main,
    input  logic              sel_a,
    input  logic              sel_b,
    output logic [ADDR_W-1:0] addr_cur,
    output logic              active,
    output beat_t             beat
);

    logic [ADDR_W-1:0] base_q;
    order_e            ord_q;
    logic              start;
    logic              all_sel;

    assign all_sel = en_main & sel_a & sel_b;
    assign start   = !sleep && ((cpu_ld && en_main) || ctl_ld);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ord_q  <= ORD_LINEAR;
            beat   <= '0;
            active <= 1'b0;
        end else if (start) begin
            if (all_sel) begin
                base_q <= addr_in;
                ord_q  <= order_e'(lin_order);
                beat   <= '0;
                active <= 1'b1;
            end else begin
                active <= 1'b0;
            end
        end else if (!sleep && active && !adv_hold) begin
            beat <= beat + 2'd1;
        end
    end

    assign addr_cur = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], beat, ord_q)};

endmodule

// File: rtl/fl_write_stage.sv
module fl_write_stage
    import fl_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  logic          active,
    input  logic [AW-1:0] addr_idx,
    input  logic          wr_all,
    input  logic          wr_bytes_en,
    input  lane_mask_t    wr_lane,
    input  word_t         din,
    output wr_req_t       req,
    output logic [AW-1:0] req_idx
);

    lane_mask_t be_now;

    assign be_now = lane_pick(wr_all, wr_bytes_en, wr_lane);

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= '0;
            req_idx <= '0;
        end else begin
            req.vld  <= !sleep && active && (|be_now);
            req.be   <= be_now;
            req.data <= din;
            req_idx  <= addr_idx;
        end
    end

endmodule

// File: rtl/fl_sram_array.sv
module fl_sram_array
    import fl_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  wr_req_t       req,
    input  logic [AW-1:0] req_idx,
    input  logic [AW-1:0] rd_idx,
    output word_t         rd_data
);

    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];
    word_t raw;
    logic  hit;

    always_ff @(posedge clk) begin
        if (req.vld) begin
            for (int i = 0; i < LANES; i++) begin
                if (req.be[i]) mem[req_idx][i*BYTE_W +: BYTE_W] <= req.data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    assign raw = mem[rd_idx];
    assign hit = req.vld && (req_idx == rd_idx);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_data[g*BYTE_W +: BYTE_W] = (hit && req.be[g]) ? req.data[g*BYTE_W +: BYTE_W]
                                                                : raw[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/fl_burst_sram.sv
module fl_burst_sram
    import fl_sram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ARR_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_ld,
    input  logic              ctl_ld,
    input  logic              adv_hold,
    input  logic              lin_order,
    input  logic              en_main,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              wr_all,
    input  logic              wr_bytes_en,
    input  logic [3:0]        wr_lane,
    input  logic [31:0]       din,
    input  logic              oe,
    input  logic              sleep,
    output logic [31:0]       dout,
    output logic              dout_oe
);

    logic [ADDR_W-1:0] addr_cur_w;
    logic              active_w;
    beat_t             beat_w;
    wr_req_t           req_w;
    logic [ARR_AW-1:0] req_idx_w;
    word_t             rd_w;

    fl_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .sleep    (sleep),
        .addr_in  (addr),
        .cpu_ld   (cpu_ld),
        .ctl_ld   (ctl_ld),
        .adv_hold (adv_hold),
        .lin_order(lin_order),
        .en_main  (en_main),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .addr_cur (addr_cur_w),
        .active   (active_w),
        .beat     (beat_w)
    );

    fl_write_stage #(.AW(ARR_AW)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .sleep      (sleep),
        .active     (active_w),
        .addr_idx   (addr_cur_w[ARR_AW-1:0]),
        .wr_all     (wr_all),
        .wr_bytes_en(wr_bytes_en),
        .wr_lane    (wr_lane),
        .din        (din),
        .req        (req_w),
        .req_idx    (req_idx_w)
    );

    fl_sram_array #(.AW(ARR_AW)) u_arr (
        .clk    (clk),
        .req    (req_w),
        .req_idx(req_idx_w),
        .rd_idx (addr_cur_w[ARR_AW-1:0]),
        .rd_data(rd_w)
    );

    assign dout    = rd_w;
    assign dout_oe = oe && active_w && !sleep;

endmodule

// File: rtl/fl_burst_sram_chk.sv
module fl_burst_sram_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic              cpu_ld,
    input logic              ctl_ld,
    input logic              adv_hold,
    input logic              en_main,
    input logic              sel_a,
    input logic              sel_b,
    input logic              dout_oe,
    input logic              active,
    input logic [1:0]        beat,
    input logic [ADDR_W-1:0] addr_cur
);

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !active);

    a_r3_beat_step: assert property (@(posedge clk) disable iff (rst)
        (active && !sleep && !cpu_ld && !ctl_ld && !adv_hold) |=> beat == $past(beat) + 2'd1);

    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !cpu_ld && !ctl_ld) |=> addr_cur[ADDR_W-1:2] == $past(addr_cur[ADDR_W-1:2]));

    a_r5_hold_word: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ld && !ctl_ld && adv_hold) |=> $stable(addr_cur));

    a_r9_cpu_ignored: assert property (@(posedge clk) disable iff (rst)
        (!sleep && cpu_ld && !en_main && !ctl_ld) |=> $stable(active));

    a_r10_deselect: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ctl_ld && !(en_main && sel_a && sel_b)) |=> !dout_oe);

    a_r12_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(addr_cur) && $stable(active)));

endmodule

bind fl_burst_sram fl_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sleep   (sleep),
    .cpu_ld  (cpu_ld),
    .ctl_ld  (ctl_ld),
    .adv_hold(adv_hold),
    .en_main (en_main),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .dout_oe (dout_oe),
    .active  (active_w),
    .beat    (beat_w),
    .addr_cur(addr_cur_w)
);

// File: tb/fl_burst_sram_tb.sv
`timescale 1ns/1ps
module fl_burst_sram_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        cpu_ld, ctl_ld, adv_hold, lin_order;
    logic        en_main, sel_a, sel_b;
    logic        wr_all, wr_bytes_en;
    logic [3:0]  wr_lane;
    logic [31:0] din;
    logic        oe, sleep;
    logic [31:0] dout;
    logic        dout_oe;

    int checks   = 0;
    int failures = 0;
    bit reported = 0;

    typedef struct {
        bit          e_oe;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t sb_q [$];

    localparam logic [31:0] W0 = 32'h1020_3040;
    localparam logic [31:0] W1 = 32'h5161_7181;
    localparam logic [31:0] W2 = 32'h92A2_B2C2;
    localparam logic [31:0] W3 = 32'hD3E3_F303;
    localparam logic [31:0] W4 = 32'h0F1E_2D3C;
    localparam logic [31:0] W3_MERGED = 32'hD3BB_F3DD;
    localparam logic [31:0] W0_MERGED = 32'h5A20_3040;

    always #5 clk = ~clk;

    fl_burst_sram u_dut (
        .clk(clk), .rst(rst), .addr(addr), .cpu_ld(cpu_ld), .ctl_ld(ctl_ld),
        .adv_hold(adv_hold), .lin_order(lin_order), .en_main(en_main),
        .sel_a(sel_a), .sel_b(sel_b), .wr_all(wr_all), .wr_bytes_en(wr_bytes_en),
        .wr_lane(wr_lane), .din(din), .oe(oe), .sleep(sleep),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic idle();
        addr = '0; cpu_ld = 0; ctl_ld = 0; adv_hold = 0; lin_order = 1;
        en_main = 1; sel_a = 1; sel_b = 1;
        wr_all = 0; wr_bytes_en = 0; wr_lane = '0; din = '0;
        oe = 1; sleep = 0;
    endtask

    // next cycle: wait for the falling edge and return controls to idle
    task automatic nxt();
        @(negedge clk);
        idle();
    endtask

    // driver side of the scoreboard: expectation for the current cycle
    task automatic expect_out(input bit e_oe, input logic [31:0] d, input string tag);
        exp_t it;
        it.e_oe = e_oe; it.d = d; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // monitor side: pops and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (it.e_oe) begin
                    if (dout_oe !== 1'b1 || dout !== it.d) begin
                        failures++;
                        $display("FAIL %s: dout_oe=%0b dout=%h expected dout_oe=1 dout=%h",
                                 it.tag, dout_oe, dout, it.d);
                    end
                end else if (dout_oe !== 1'b0) begin
                    failures++;
                    $display("FAIL %s: dout_oe=%0b expected dout_oe=0", it.tag, dout_oe);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!reported) begin
            failures++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1; idle();
        repeat (3) @(negedge clk);

        nxt(); rst = 0; expect_out(0, '0, "R1 deselected after reset");

        // linear group write at 0x10..0x13, oe low while writing
        nxt(); ctl_ld = 1; addr = 16'h0010; lin_order = 1;
        nxt(); oe = 0; wr_all = 1; din = W0;
        nxt(); oe = 0; wr_all = 1; din = W1;
        nxt(); oe = 0; wr_all = 1; din = W2;
        nxt(); oe = 0; wr_all = 1; din = W3;
        nxt(); expect_out(1, W0, "R3 wrap to first beat");
        nxt(); expect_out(1, W1, "R3 linear beat 1");
        nxt(); expect_out(1, W2, "R3 linear beat 2");
        nxt(); expect_out(1, W3, "R3 linear beat 3");

        // interleaved group from low bits 01: 1,0,3,2
        nxt(); ctl_ld = 1; addr = 16'h0011; lin_order = 0;
        nxt(); expect_out(1, W1, "R2 flow-through first beat");
        nxt(); expect_out(1, W0, "R4 interleaved beat 1");
        nxt(); expect_out(1, W3, "R4 interleaved beat 2");
        nxt(); expect_out(1, W2, "R4 interleaved beat 3");

        // hold, ignored processor strobe, writes
        nxt(); ctl_ld = 1; addr = 16'h0010; lin_order = 1;
        nxt(); adv_hold = 1; expect_out(1, W0, "R5 before hold");
        nxt(); expect_out(1, W0, "R5 word repeated under hold");
        nxt(); cpu_ld = 1; en_main = 0; addr = 16'h0013; expect_out(1, W1, "R5 resumes after hold");
        nxt(); wr_all = 1; wr_bytes_en = 0; wr_lane = 4'b0000; din = W4;
        expect_out(1, W2, "R9 strobe ignored, burst continues");
        nxt(); wr_bytes_en = 1; wr_lane = 4'b0101; din = 32'hAABB_CCDD; expect_out(1, W3, "R7 word before byte write");
        nxt(); wr_bytes_en = 0; wr_lane = 4'b1111; din = 32'hFFFF_FFFF; expect_out(1, W0, "R3 wrap second group");
        nxt(); ctl_ld = 1; addr = 16'h0012; lin_order = 1; expect_out(1, W1, "R7 lanes without enable");
        nxt(); expect_out(1, W4, "R6 all lanes written");
        nxt(); expect_out(1, W3_MERGED, "R7 selected lanes only");
        nxt(); adv_hold = 1; wr_bytes_en = 1; wr_lane = 4'b1000; din = 32'h5A00_0000;
        expect_out(1, W0, "R7 no write without byte enable");
        nxt(); adv_hold = 1; expect_out(1, W0_MERGED, "R8 read right after write merges");
        nxt(); oe = 0; expect_out(0, '0, "R11 oe gates same cycle");
        nxt(); expect_out(1, W1, "R11 state unaffected by oe");

        // sleep blocks load, write and step
        nxt(); sleep = 1; ctl_ld = 1; addr = 16'h0010; wr_all = 1; din = 32'hDEAD_BEEF;
        expect_out(0, '0, "R12 output off in sleep");
        nxt(); expect_out(1, W4, "R12 no load, write or step in sleep");

        // deselect paths
        nxt(); ctl_ld = 1; sel_b = 0; addr = 16'h0010; expect_out(1, W3_MERGED, "R3 beat before deselect");
        nxt(); expect_out(0, '0, "R10 controller deselect");
        nxt(); cpu_ld = 1; addr = 16'h0011; expect_out(0, '0, "R10 stays deselected");
        nxt(); cpu_ld = 1; sel_a = 0; addr = 16'h0012; expect_out(1, W1, "R2 processor load");
        nxt(); expect_out(0, '0, "R10 processor deselect");

        nxt();
        repeat (2) @(negedge clk);
        #4;
        report();
        $finish;
    end

endmodule